// File: doc/BRIEF.md
# Shared Interrupt Source Conditioner

This block accepts a parameterizable set of external interrupt lines (`NUM_SRC`, 32 by default, up to 256) and turns each into a clean pending bit. Every source carries four configuration bits: a polarity bit, a trigger-type bit, a dual-edge bit and an enable bit. A level source reports pending while its polarity-adjusted input is active. An edge source reports pending from a sticky latch that a qualifying transition sets. Before any detection, each raw line passes through a two-flop synchronizer.

Software reaches the block through a 32-bit, word-addressed register port with a single write strobe and a combinational read path. The six-bit address splits into a three-bit bank code in `regAddr[5:3]` and a three-bit word index in `regAddr[2:0]`. Source n sits in word n/32, bit n%32, of every per-source bank. The enable bits are written through separate set and clear banks, and a third, read-only bank shows their current values. One command register sets or clears the edge latch of any single source. The block drives `reqOut` high for each source that is both pending and enabled. The next stage, which does routing or arbitration, uses this vector.

Top module: `irq_source_conditioner`

## Requirements
- R1: After reset, every polarity, trigger, dual-edge and enable bit reads 0, every edge latch is clear, and `reqOut` is all zero.
- R2: Banks 0 (polarity), 1 (trigger, 1 = edge, 0 = level) and 2 (dual-edge) can be read and written. Source n maps to word n/32, bit n%32. Bits above `NUM_SRC-1` and word indices at or above the number of implemented words read as 0, and writes to them have no effect.
- R3: A write to bank 3 (enable-set) enables each source whose data bit is 1 and leaves sources with a 0 bit unchanged.
- R4: A write to bank 4 (enable-clear) disables each source whose data bit is 1 and leaves sources with a 0 bit unchanged.
- R5: Bank 5 (enable view, 1 = enabled) and bank 6 (pending view) are read-only. Writes to them change no state. Banks 3, 4 and 7 read as 0.
- R6: A level source (trigger 0) is pending while its synchronized input equals its polarity bit (1 = active-high, 0 = active-low). An input change appears in the pending view no later than the third rising clock edge after it.
- R7: An edge source (trigger 1, dual-edge 0) latches a rising transition when polarity is 1 and a falling transition when polarity is 0. The latch holds after the input returns, and an edge source's pending bit equals its latch.
- R8: An edge source with dual-edge 1 latches both rising and falling transitions, whatever its polarity.
- R9: A write to bank 7 (edge command) sets (data bit 31 = 1) or clears (bit 31 = 0) the edge latch of the source numbered in data bits 7:0. An index at or above `NUM_SRC` changes nothing. When a hardware event and the command hit the same latch in the same cycle, the event wins.
- R10: Bit n of `reqOut` is 1 exactly when source n is both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_SRC | Raw external interrupt lines |
| regAddr | input | 6 | Register word address: bank in bits 5:3, word in bits 2:0 |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| reqOut | output | NUM_SRC | Qualified requests, pending AND enabled |

## Verification
The bench builds the block with `NUM_SRC` = 40. This gives two words per bank, and the second word holds only eight implemented bits. With this width the bench can check the unimplemented upper bits of word 1, the empty word 2, and the placement of source 39 at word 1, bit 7. An edge-command index of 45 falls inside the 8-bit field but past the last source, so the out-of-range case can also be exercised.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  localparam int WORD_W   = 32;
  localparam int WSEL_W   = 3;
  localparam int BANK_W   = 3;
  localparam int ADDR_W   = BANK_W + WSEL_W;
  localparam int IDX_W    = 8;
  localparam int MAX_SRC  = (1 << WSEL_W) * WORD_W;

  typedef enum logic [BANK_W-1:0] {
    BANK_POL   = 3'd0,
    BANK_TRIG  = 3'd1,
    BANK_DUAL  = 3'd2,
    BANK_ESET  = 3'd3,
    BANK_ECLR  = 3'd4,
    BANK_EVIEW = 3'd5,
    BANK_PEND  = 3'd6,
    BANK_EDGE  = 3'd7
  } bank_e;

  typedef struct packed {
    logic              wrPol;
    logic              wrTrig;
    logic              wrDual;
    logic              wrSet;
    logic              wrClr;
    logic              edgeCmd;
    logic [WSEL_W-1:0] wordSel;
    bank_e             rdBank;
  } strobe_t;
endpackage

// File: rtl/irq_cond_ctrl.sv
module irq_cond_ctrl
  import irq_cond_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobe_t           stb
);
  bank_e bank;
  assign bank = bank_e'(regAddr[ADDR_W-1:WSEL_W]);

  always_comb begin
    stb         = '0;
    stb.wordSel = regAddr[WSEL_W-1:0];
    stb.rdBank  = bank;
    if (regWrEn) begin
      unique case (bank)
        BANK_POL:  stb.wrPol   = 1'b1;
        BANK_TRIG: stb.wrTrig  = 1'b1;
        BANK_DUAL: stb.wrDual  = 1'b1;
        BANK_ESET: stb.wrSet   = 1'b1;
        BANK_ECLR: stb.wrClr   = 1'b1;
        BANK_EDGE: stb.edgeCmd = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/irq_cond_datapath.sv
module irq_cond_datapath
  import irq_cond_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  strobe_t            stb,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] enMask,
  output logic [NUM_SRC-1:0] reqOut
);
  localparam int NUM_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = NUM_WORDS * WORD_W;

  logic [NUM_SRC-1:0] polQ, trigQ, dualQ, maskQ, latchQ;
  logic [NUM_SRC-1:0] polNext, trigNext, dualNext, maskNext, latchNext;
  logic [NUM_SRC-1:0] sync1Q, sync2Q, prevQ;
  logic [NUM_SRC-1:0] riseEv, fallEv, edgeEv, levelAct;

  // Two-flop synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1Q <= '0;
      sync2Q <= '0;
      prevQ  <= '0;
    end else begin
      sync1Q <= irqIn;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q;
    end
  end

  assign riseEv   = sync2Q & ~prevQ;
  assign fallEv   = ~sync2Q & prevQ;
  assign edgeEv   = trigQ & ((dualQ & (riseEv | fallEv)) |
                             (~dualQ & polQ & riseEv) |
                             (~dualQ & ~polQ & fallEv));
  assign levelAct = ~(sync2Q ^ polQ);

  // Per-source next-state: word n/32, bit n%32
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int              BIT  = n % WORD_W;
    localparam logic [WSEL_W-1:0] WSEL = WSEL_W'(n / WORD_W);
    localparam logic [IDX_W-1:0]  IDX  = IDX_W'(n);
    logic hit, cmdHit;
    assign hit    = (stb.wordSel == WSEL);
    assign cmdHit = stb.edgeCmd && (wrData[IDX_W-1:0] == IDX);

    assign polNext[n]  = (stb.wrPol  && hit) ? wrData[BIT] : polQ[n];
    assign trigNext[n] = (stb.wrTrig && hit) ? wrData[BIT] : trigQ[n];
    assign dualNext[n] = (stb.wrDual && hit) ? wrData[BIT] : dualQ[n];
    assign maskNext[n] = (stb.wrSet && hit && wrData[BIT]) ? 1'b1 :
                         (stb.wrClr && hit && wrData[BIT]) ? 1'b0 : maskQ[n];
    // a hardware event beats a software clear in the same cycle
    assign latchNext[n] = edgeEv[n] ? 1'b1 :
                          cmdHit    ? wrData[WORD_W-1] : latchQ[n];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ   <= '0;
      trigQ  <= '0;
      dualQ  <= '0;
      maskQ  <= '0;
      latchQ <= '0;
    end else begin
      polQ   <= polNext;
      trigQ  <= trigNext;
      dualQ  <= dualNext;
      maskQ  <= maskNext;
      latchQ <= latchNext;
    end
  end

  assign pendVec = (trigQ & latchQ) | (~trigQ & levelAct);
  assign enMask  = maskQ;
  assign reqOut  = pendVec & maskQ;

  // Read-back mux
  logic [PAD_W-1:0] polPad, trigPad, dualPad, maskPad, pendPad, selPad;
  assign polPad  = PAD_W'(polQ);
  assign trigPad = PAD_W'(trigQ);
  assign dualPad = PAD_W'(dualQ);
  assign maskPad = PAD_W'(maskQ);
  assign pendPad = PAD_W'(pendVec);

  always_comb begin
    unique case (stb.rdBank)
      BANK_POL:   selPad = polPad;
      BANK_TRIG:  selPad = trigPad;
      BANK_DUAL:  selPad = dualPad;
      BANK_EVIEW: selPad = maskPad;
      BANK_PEND:  selPad = pendPad;
      default:    selPad = '0;
    endcase
  end

  always_comb begin
    rdData = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (int'(stb.wordSel) == w) rdData = selPad[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/irq_source_conditioner.sv
module irq_source_conditioner
  import irq_cond_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [5:0]         regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic [NUM_SRC-1:0] reqOut
);
  strobe_t            stb;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] enMask;

  irq_cond_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .stb     (stb)
  );

  irq_cond_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .stb     (stb),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .pendVec (pendVec),
    .enMask  (enMask),
    .reqOut  (reqOut)
  );
endmodule

// File: rtl/irq_cond_checker.sv
module irq_cond_checker #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [5:0]         regAddr,
  input logic               regWrEn,
  input logic [31:0]        regWrData,
  input logic [NUM_SRC-1:0] enMask,
  input logic [NUM_SRC-1:0] reqOut
);
  localparam int          NUM_WORDS = (NUM_SRC + 31) / 32;
  localparam int          PAD_W     = NUM_WORDS * 32;
  localparam int          LO_BITS   = (NUM_SRC < 32) ? NUM_SRC : 32;
  localparam logic [31:0] LO_VALID  = (LO_BITS == 32) ? 32'hFFFF_FFFF
                                                      : ((32'd1 << LO_BITS) - 32'd1);

  logic [PAD_W-1:0] maskPad;
  assign maskPad = PAD_W'(enMask);

  logic setWord0, clrWord0, viewWrite;
  assign setWord0  = regWrEn && (regAddr == 6'o30);
  assign clrWord0  = regWrEn && (regAddr == 6'o40);
  assign viewWrite = regWrEn && (regAddr[5:3] == 3'd5);

  // R3: ones written to the set bank are enabled afterwards
  assert_set_enables_R3: assert property (@(posedge clk) disable iff (!rstN)
    setWord0 |=> ((maskPad[31:0] & $past(regWrData) & LO_VALID) ==
                  ($past(regWrData) & LO_VALID)));

  // R4: ones written to the clear bank are disabled afterwards
  assert_clr_disables_R4: assert property (@(posedge clk) disable iff (!rstN)
    clrWord0 |=> ((maskPad[31:0] & $past(regWrData)) == 32'd0));

  // R5: writes to the read-only enable view leave the enables untouched
  assert_view_readonly_R5: assert property (@(posedge clk) disable iff (!rstN)
    viewWrite |=> (enMask == $past(enMask)));

  // R10: no request leaves a disabled source
  assert_req_needs_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((reqOut & ~enMask) == '0));
endmodule

bind irq_source_conditioner irq_cond_checker #(.NUM_SRC(NUM_SRC)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .enMask    (enMask),
  .reqOut    (reqOut)
);

// File: tb/tb_irq_source_conditioner.sv
module tb_irq_source_conditioner;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC    = 40;

  logic               clk = 1'b0;
  logic               rstN;
  logic [NUM_SRC-1:0] irqIn;
  logic [5:0]         regAddr;
  logic               regWrEn;
  logic [31:0]        regWrData;
  logic [31:0]        regRdData;
  logic [NUM_SRC-1:0] reqOut;

  irq_source_conditioner #(.NUM_SRC(NUM_SRC)) dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .reqOut(reqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          isReq;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t sbQ[$];
  int    checkCount = 0;
  int    failCount  = 0;
  bit    finished   = 1'b0;

  // Monitor: compares a quarter period after the falling edge, away from posedge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sbQ.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it  = sbQ.pop_front();
        act = it.isReq ? 64'(reqOut) : 64'(regRdData);
        checkCount++;
        if (act !== it.exp) begin
          failCount++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic regWrite(input logic [2:0] bank, input logic [2:0] word,
                          input logic [31:0] data);
    @(negedge clk);
    regAddr   = {bank, word};
    regWrData = data;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic expectReg(input logic [2:0] bank, input logic [2:0] word,
                           input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    regAddr  = {bank, word};
    it.isReq = 1'b0;
    it.exp   = 64'(exp);
    it.tag   = tag;
    sbQ.push_back(it);
    wait (sbQ.size() == 0);
  endtask

  task automatic expectReq(input logic [63:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    it.isReq = 1'b1;
    it.exp   = exp;
    it.tag   = tag;
    sbQ.push_back(it);
    wait (sbQ.size() == 0);
  endtask

  task automatic setIrq(input int idx, input logic val);
    @(negedge clk);
    irqIn[idx] = val;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    rstN      = 1'b0;
    irqIn     = '1;
    regAddr   = '0;
    regWrEn   = 1'b0;
    regWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();

    // R1 reset state
    expectReg(3'd0, 3'd0, 32'h0, "R1 polarity word0");
    expectReg(3'd1, 3'd1, 32'h0, "R1 trigger word1");
    expectReg(3'd2, 3'd0, 32'h0, "R1 dual word0");
    expectReg(3'd5, 3'd0, 32'h0, "R1 enable view word0");
    expectReq(64'h0, "R1 reqOut");

    // R2 read/write banks, partial and absent words
    regWrite(3'd0, 3'd0, 32'hA5A5_0F0F);
    expectReg(3'd0, 3'd0, 32'hA5A5_0F0F, "R2 polarity word0");
    regWrite(3'd1, 3'd1, 32'hFFFF_FFFF);
    expectReg(3'd1, 3'd1, 32'h0000_00FF, "R2 trigger word1 upper bits absent");
    regWrite(3'd0, 3'd2, 32'hFFFF_FFFF);
    expectReg(3'd0, 3'd2, 32'h0, "R2 polarity word2 absent");
    regWrite(3'd0, 3'd0, 32'h0);
    regWrite(3'd1, 3'd1, 32'h0);
    expectReg(3'd1, 3'd1, 32'h0, "R2 trigger word1 cleared");

    // R3 / R4 enable set and clear
    regWrite(3'd3, 3'd0, 32'h0000_00F0);
    expectReg(3'd5, 3'd0, 32'h0000_00F0, "R3 set 0xF0");
    regWrite(3'd3, 3'd0, 32'h0000_0003);
    expectReg(3'd5, 3'd0, 32'h0000_00F3, "R3 zeros keep prior enables");
    regWrite(3'd4, 3'd0, 32'h0000_0010);
    expectReg(3'd5, 3'd0, 32'h0000_00E3, "R4 clear bit4 only");

    // R5 read-only banks
    regWrite(3'd5, 3'd0, 32'hFFFF_FFFF);
    expectReg(3'd5, 3'd0, 32'h0000_00E3, "R5 enable view write ignored");
    regWrite(3'd6, 3'd0, 32'hFFFF_FFFF);
    expectReg(3'd6, 3'd0, 32'h0, "R5 pending write ignored");
    expectReg(3'd3, 3'd0, 32'h0, "R5 set bank reads zero");

    // R6 level sources: src0 active-high, src1 active-low, all inputs high
    regWrite(3'd0, 3'd0, 32'h0000_0001);
    settle();
    expectReg(3'd6, 3'd0, 32'h0000_0001, "R6 active-high level asserted");
    setIrq(1, 1'b0);
    settle();
    expectReg(3'd6, 3'd0, 32'h0000_0003, "R6 active-low level asserted");
    setIrq(0, 1'b0);
    settle();
    expectReg(3'd6, 3'd0, 32'h0000_0002, "R6 active-high level released");

    // R7 / R8 edge sources: src4 rising, src5 falling, src6 dual
    regWrite(3'd0, 3'd0, 32'h0000_0011);
    regWrite(3'd1, 3'd0, 32'h0000_0070);
    regWrite(3'd2, 3'd0, 32'h0000_0040);
    settle();
    expectReg(3'd6, 3'd0, 32'h0000_0002, "R7 no event while inputs steady");
    setIrq(4, 1'b0); setIrq(5, 1'b0); setIrq(6, 1'b0);
    settle();
    expectReg(3'd6, 3'd0, 32'h0000_0062, "R7 falling latched src5, R8 src6");
    setIrq(4, 1'b1); setIrq(5, 1'b1); setIrq(6, 1'b1);
    settle();
    expectReg(3'd6, 3'd0, 32'h0000_0072, "R7 rising latched src4");
    setIrq(4, 1'b0);
    settle();
    expectReg(3'd6, 3'd0, 32'h0000_0072, "R7 latch sticky after input drops");

    // R9 command clear then R8 dual rising on active-low source
    setIrq(6, 1'b0);
    settle();
    regWrite(3'd7, 3'd0, 32'h0000_0006);
    expectReg(3'd6, 3'd0, 32'h0000_0032, "R9 clear src6 latch");
    setIrq(6, 1'b1);
    settle();
    expectReg(3'd6, 3'd0, 32'h0000_0072, "R8 dual rising with polarity 0");
    regWrite(3'd7, 3'd0, 32'h0000_0005);
    expectReg(3'd6, 3'd0, 32'h0000_0052, "R9 clear src5 latch");

    // R9 set by index in word1, out-of-range index
    regWrite(3'd1, 3'd1, 32'h0000_0080);
    regWrite(3'd7, 3'd0, 32'h8000_0027);
    expectReg(3'd6, 3'd1, 32'h0000_0080, "R9 set src39 at word1 bit7");
    regWrite(3'd7, 3'd0, 32'h8000_002D);
    expectReg(3'd6, 3'd1, 32'h0000_0080, "R9 index 45 ignored word1");
    expectReg(3'd6, 3'd0, 32'h0000_0052, "R9 index 45 ignored word0");
    regWrite(3'd7, 3'd0, 32'h0000_0027);
    expectReg(3'd6, 3'd1, 32'h0, "R9 clear src39");

    // R10 qualified requests
    expectReq(64'h42, "R10 pending 0x52 with enables 0xE3");
    regWrite(3'd3, 3'd0, 32'h0000_0010);
    expectReq(64'h52, "R10 enabling src4 adds request");
    regWrite(3'd4, 3'd0, 32'hFFFF_FFFF);
    expectReq(64'h0, "R10 all disabled");
    expectReg(3'd5, 3'd0, 32'h0, "R4 clear all word0");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule